// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 8K by 8 bits. The host issues one request at a time with a level `req_i`, a direction flag, an address and write data, and keeps them steady until `ack_o` pulses. The controller captures the request, runs the memory strobes for a whole number of clock cycles derived from the memory's timing limits, and then returns to idle. On a read, the captured byte appears on `rdata_o` in the same cycle as the acknowledge.

The memory side has a registered address bus and two chip selects of opposite polarity. It also has an active-low write strobe and an active-low output enable. The bidirectional data bus is split into a drive value, a drive enable and a sampled input, so that the pad cell stays outside the block. Writes are strobed by the write enable while the output enable is held high, which allows the shorter write pulse. After every read the controller waits for the memory's output float time before it can drive the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `mem_ce_n_o`=1, `mem_ce_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0 and `ack_o`=0. `rdata_o` resets to 0.
- R2: During a read, the memory is selected (`mem_ce_n_o`=0 and `mem_ce_o`=1) with `mem_oe_n_o`=0, `mem_we_n_o`=1 and the data driver off. `mem_oe_n_o` stays low for exactly RD_CYC consecutive cycles (3 at default parameters).
- R3: `rdata_o` takes the value of `mem_dq_i` sampled on the last read-access cycle and is valid in the cycle where `ack_o` is high. `ack_o` is high for one cycle per request. `rdata_o` keeps its value until the next read completes.
- R4: During a write, the memory is selected with `mem_oe_n_o`=1 and `mem_dq_oe_o`=1. `mem_we_n_o` stays low for exactly WR_CYC consecutive cycles (3 at default parameters).
- R5: `mem_addr_o` and `mem_dq_o` are unchanged from the cycle where `mem_we_n_o` falls through the cycle where it rises. The memory stays selected in that rising cycle, so the data is latched at the rising write enable.
- R6: `mem_dq_oe_o`=1 never coincides with `mem_oe_n_o`=0. When `mem_dq_oe_o` rises, `mem_oe_n_o` has been high for more than HZ_CYC preceding cycles.
- R7: A request is accepted only while idle. Address, direction and write data are captured at acceptance, so later changes on the host inputs do not affect the operation. A request held during a busy period is taken once the controller is idle again.
- R8: RD_CYC = ceil(max(T_AA_PS, T_RC_PS, T_OE_PS) / CLK_PS), WR_CYC = ceil(max(T_WP_PS, T_AW_PS, T_DS_PS) / CLK_PS) and HZ_CYC = ceil(T_OHZ_PS / CLK_PS). Each of these is at least 1.
- R9: If a request is accepted on a clock edge, `ack_o` is high in the cycle that begins RD_CYC edges later for a read, or WR_CYC edges later for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with acknowledge |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_ce_o | output | 1 | Chip select, active high |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data bus drive value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus sampled value |

## Verification
The bench uses the default parameters: a 4 ns clock period, with 12 ns access, 10 ns address-to-write-end and 6 ns float times. These give RD_CYC=3, WR_CYC=3 and HZ_CYC=2, so read pulses, write pulses and turnaround gaps all span several cycles and an off-by-one in any of them is visible. The memory model returns valid data only from the third read cycle onward. It latches on the rising write enable, so reads sampled early and writes whose data or address moves before the strobe rises both produce data miscompares. Back-to-back mixed traffic puts a write right behind a read, which exercises the minimum float gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_WREC
  } ctrl_state_e;

  function automatic int unsigned ps_to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 3,
  parameter int unsigned HZ_CYC = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  output ctrl_state_e state_d_o,
  output logic        accept_o,
  output logic        capture_o,
  output logic        ack_o
);

  ctrl_state_e      state_q, state_d;
  logic             done;
  logic             load;
  logic [CNT_W-1:0] load_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = we_i ? ST_WR : ST_RD;
      ST_RD:   if (done)  state_d = ST_TURN;
      ST_TURN: if (done)  state_d = ST_IDLE;
      ST_WR:   if (done)  state_d = ST_WREC;
      ST_WREC:            state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  assign load = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_RD:   load_val = CNT_W'(RD_CYC - 1);
      ST_TURN: load_val = CNT_W'(HZ_CYC - 1);
      ST_WR:   load_val = CNT_W'(WR_CYC - 1);
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_o   <= (state_q == ST_RD && state_d == ST_TURN) ||
                 (state_q == ST_WR && state_d == ST_WREC);
    end
  end

  assign state_d_o = state_d;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RD) && done;

  // R3: one acknowledge per operation
  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R7: accepted request always leaves idle
  assert_accept_leaves_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (state_q == ST_RD || state_q == ST_WR));

  // R7: no acceptance outside idle
  assert_busy_no_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !accept_o);

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 3,
  parameter int unsigned HZ_CYC = 2,
  parameter int unsigned MAX_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_state_e       state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  localparam int unsigned MON_W = $clog2(MAX_CYC + 3) + 1;

  logic sel_d, we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    sel_d   = (state_d_i == ST_RD) || (state_d_i == ST_WR) || (state_d_i == ST_WREC);
    we_n_d  = (state_d_i != ST_WR);
    oe_n_d  = (state_d_i != ST_RD);
    dq_oe_d = (state_d_i == ST_WR) || (state_d_i == ST_WREC);
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_n_o  <= 1'b1;
      mem_ce_o    <= 1'b0;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_ce_n_o  <= ~sel_d;
      mem_ce_o    <= sel_d;
      mem_we_n_o  <= we_n_d;
      mem_oe_n_o  <= oe_n_d;
      mem_dq_oe_o <= dq_oe_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end

  // ---- protocol checks ----
  logic             mem_sel;
  logic [MON_W-1:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;
  localparam logic [MON_W-1:0] MON_MAX = '1;

  assign mem_sel = !mem_ce_n_o && mem_ce_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
      oe_hi_cnt <= MON_MAX;
    end else begin
      we_lo_cnt <= mem_we_n_o ? '0 : ((we_lo_cnt == MON_MAX) ? we_lo_cnt : we_lo_cnt + 1'b1);
      oe_lo_cnt <= mem_oe_n_o ? '0 : ((oe_lo_cnt == MON_MAX) ? oe_lo_cnt : oe_lo_cnt + 1'b1);
      oe_hi_cnt <= !mem_oe_n_o ? '0 : ((oe_hi_cnt == MON_MAX) ? oe_hi_cnt : oe_hi_cnt + 1'b1);
    end
  end

  assert_idle_safe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_sel |-> (mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  assert_rd_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_sel && mem_we_n_o));

  assert_rd_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (oe_lo_cnt == MON_W'(RD_CYC)));

  assert_wr_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_sel && mem_oe_n_o && mem_dq_oe_o));

  assert_wr_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt == MON_W'(WR_CYC)));

  assert_wr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |=> ($stable(mem_addr_o) && $stable(mem_dq_o) && mem_sel));

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

  assert_turnaround_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_hi_cnt > MON_W'(HZ_CYC)));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_AA_PS   = 12000,
  parameter int unsigned T_RC_PS   = 12000,
  parameter int unsigned T_OE_PS   = 6000,
  parameter int unsigned T_WP_PS   = 8000,
  parameter int unsigned T_AW_PS   = 10000,
  parameter int unsigned T_DS_PS   = 6000,
  parameter int unsigned T_OHZ_PS  = 6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  // R8: interval to cycle conversion
  localparam int unsigned RD_CYC  = ps_to_cycles(max3(T_AA_PS, T_RC_PS, T_OE_PS), CLK_PS);
  localparam int unsigned WR_CYC  = ps_to_cycles(max3(T_WP_PS, T_AW_PS, T_DS_PS), CLK_PS);
  localparam int unsigned HZ_CYC  = ps_to_cycles(T_OHZ_PS, CLK_PS);
  localparam int unsigned MAX_CYC = max3(RD_CYC, WR_CYC, HZ_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e state_d;
  logic        accept;
  logic        capture;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .HZ_CYC (HZ_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .state_d_o (state_d),
    .accept_o  (accept),
    .capture_o (capture),
    .ack_o     (ack_o)
  );

  sram_pin_drive #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .HZ_CYC  (HZ_CYC),
    .MAX_CYC (MAX_CYC)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_d_i   (state_d),
    .accept_i    (accept),
    .capture_i   (capture),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_dq_i    (mem_dq_i),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce_o    (mem_ce_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

  // R8: derived counts are never zero
  initial begin
    assert_cycles_nonzero_R8: assert (RD_CYC >= 1 && WR_CYC >= 1 && HZ_CYC >= 1);
  end

endmodule

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;

  localparam int unsigned CLK_PS = 4000;

  function automatic int unsigned cyc_of(input int unsigned t_ps);
    int unsigned n;
    n = (t_ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  // R8: expected counts from the timing limits (12/12/6, 8/10/6, 6 ns)
  localparam int unsigned RD_CYC = cyc_of(12000);
  localparam int unsigned WR_CYC = cyc_of(10000);
  localparam int unsigned HZ_CYC = cyc_of(6000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic [12:0] mem_addr_o;
  logic        mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0;
  int v_r2 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0;
  int n_rd_pulse = 0, n_wr_pulse = 0;

  sram_async_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack_o), .rdata_o(rdata_o), .mem_addr_o(mem_addr_o), .mem_ce_n_o(mem_ce_n_o),
    .mem_ce_o(mem_ce_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  initial forever #2 clk = ~clk;

  // ---- memory model: addresses used keep addr[12:10] == addr[2:0] ----
  logic [7:0] mem_arr [0:1023];
  logic [7:0] ref_arr [0:1023];
  int         rd_age = 0;
  wire        m_sel  = !mem_ce_n_o && mem_ce_o;
  wire        m_read = m_sel && !mem_oe_n_o && mem_we_n_o;
  wire        a_ok   = (mem_addr_o[12:10] == mem_addr_o[2:0]);

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [12:0] mk_addr(input logic [9:0] idx);
    return {idx[2:0], idx};
  endfunction

  // data becomes valid only once the access time has elapsed
  assign mem_dq_i = (m_read && a_ok && rd_age >= int'(RD_CYC) - 1) ? mem_arr[mem_addr_o[9:0]] : 8'hEE;

  always @(posedge clk) rd_age <= m_read ? rd_age + 1 : 0;

  always @(posedge mem_we_no_evt) ;
  wire mem_we_no_evt = mem_we_n_o;

  always @(posedge mem_we_n_o) begin
    if (rst_n && m_sel) begin
      if (!a_ok) v_r5++;
      else mem_arr[mem_addr_o[9:0]] = mem_dq_o;
    end
  end

  // ---- pin monitor, sampled at falling edge ----
  logic        p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
  int          we_cnt = 0, oe_cnt = 0, hz_cnt = 1000;
  logic [12:0] h_addr = '0;
  logic [7:0]  h_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe_o && !mem_oe_n_o) v_r6++;
      if (mem_dq_oe_o && !p_dqoe && hz_cnt <= int'(HZ_CYC)) v_r6++;
      if (!mem_oe_n_o) begin
        if (!m_sel || !mem_we_n_o || mem_dq_oe_o) v_r2++;
        oe_cnt++;
      end else begin
        if (!p_oe) begin
          n_rd_pulse++;
          if (oe_cnt != int'(RD_CYC)) v_r2++;
        end
        oe_cnt = 0;
      end
      if (!mem_we_n_o) begin
        if (!m_sel || !mem_oe_n_o || !mem_dq_oe_o) v_r4++;
        if (p_we) begin h_addr = mem_addr_o; h_dq = mem_dq_o; end
        else if (mem_addr_o != h_addr || mem_dq_o != h_dq) v_r5++;
        we_cnt++;
      end else begin
        if (!p_we) begin
          n_wr_pulse++;
          if (we_cnt != int'(WR_CYC)) v_r4++;
          if (!m_sel || mem_addr_o != h_addr || mem_dq_o != h_dq) v_r5++;
        end
        we_cnt = 0;
      end
      hz_cnt = !mem_oe_n_o ? 0 : ((hz_cnt < 1000) ? hz_cnt + 1 : hz_cnt);
      p_we = mem_we_n_o; p_oe = mem_oe_n_o; p_dqoe = mem_dq_oe_o;
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    check(mem_ce_n_o && !mem_ce_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !ack_o, rq,
          {mem_ce_n_o, mem_ce_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, ack_o}, 6'b101100);
  endtask

  // called at a falling edge; leaves at a falling edge
  task automatic host_op(input bit wr, input logic [9:0] idx, input logic [7:0] d, input bit chk_lat);
    int cyc = 0;
    logic [12:0] a;
    a = mk_addr(idx);
    req = 1'b1; we = wr; addr = a; wdata = d;
    do begin
      @(negedge clk); cyc++;
      if (!ack_o && cyc == 1 && chk_lat) begin
        // R7: scramble host inputs after acceptance
        addr = ~a; wdata = ~d;
      end
    end while (!ack_o && cyc < 50);
    req = 1'b0; addr = ~a; wdata = ~d;
    check(ack_o, "R7 ack seen", ack_o, 1);
    if (chk_lat) check(cyc == int'(wr ? WR_CYC : RD_CYC) + 1, "R9 ack latency", cyc,
                       int'(wr ? WR_CYC : RD_CYC) + 1);
    if (wr) ref_arr[idx] = d;
    else check(rdata_o == ref_arr[idx], "R3 read data", rdata_o, ref_arr[idx]);
    @(negedge clk);
    check(!ack_o, "R3 ack single cycle", ack_o, 0);
  endtask

  task automatic op_gap(input bit wr, input logic [9:0] idx, input logic [7:0] d);
    host_op(wr, idx, d, 1'b1);
    @(negedge clk);
    check_idle("R1 idle after op");
  endtask

  int seed;
  logic [7:0] held;

  initial begin
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 1024; i++) begin
      mem_arr[i] = init_val(i);
      ref_arr[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    check(rdata_o == 8'h00, "R1 rdata reset", rdata_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    // directed corners
    op_gap(1'b0, 10'h000, 8'h00);
    op_gap(1'b1, 10'h000, 8'hFF);
    op_gap(1'b0, 10'h000, 8'h00);
    op_gap(1'b1, 10'h3FF, 8'h00);
    op_gap(1'b0, 10'h3FF, 8'h00);
    op_gap(1'b1, 10'h3FF, 8'hA5);
    op_gap(1'b1, 10'h3FF, 8'h5A);
    op_gap(1'b0, 10'h3FF, 8'h00);
    check(uut.mem_addr_o == 13'h1FFF, "R2 top address driven", mem_addr_o, 13'h1FFF);

    // R3: rdata holds across a write
    op_gap(1'b0, 10'h155, 8'h00);
    held = rdata_o;
    op_gap(1'b1, 10'h2AA, 8'h3C);
    check(rdata_o == held, "R3 rdata held over write", rdata_o, held);

    // constrained random, idle gaps
    for (int k = 0; k < 300; k++) begin
      op_gap(1'($urandom_range(0, 1)), 10'($urandom_range(0, 63) * 16 + $urandom_range(0, 3)),
             8'($urandom));
    end

    // back-to-back: read directly followed by write exercises the float gap (R6, R7)
    for (int k = 0; k < 120; k++) begin
      host_op(1'($urandom_range(0, 1)), 10'($urandom_range(0, 31)), 8'($urandom), 1'b0);
    end
    repeat (4) @(negedge clk);
    check_idle("R1 idle at end");

    check(v_r2 == 0, "R2 read strobes and width", v_r2, 0);
    check(v_r4 == 0, "R4 write strobes and width", v_r4, 0);
    check(v_r5 == 0, "R5 write address/data stability", v_r5, 0);
    check(v_r6 == 0, "R6 bus contention/turnaround", v_r6, 0);
    check(n_rd_pulse > 100 && n_wr_pulse > 100, "R8 pulses observed", n_rd_pulse, 100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule